// File: doc/BRIEF.md
# Split Direct-Mapped Address Translator

This block turns 32-bit virtual addresses into physical addresses for a processor pipeline. It keeps two independent direct-mapped lookup tables. One serves instruction fetches and the other serves data loads and stores. Each table entry holds a tag word and a frame word. The tag word carries the virtual page number and a valid flag. The frame word carries the physical page frame and six permission bits, split into a user group and a supervisor group.

Every lookup states its access kind (load, store or fetch) and the privilege mode. One clock later the block returns four things: the physical address, the granted permissions, a two-bit result code, and, when the lookup fails, a one-cycle exception request with a cause. The faulting virtual address is captured. At the same moment the load-linked reservation address is cleared to all ones.

Software loads table entries one word at a time through a write port. Each translation path has its own enable bit, taken from the status register. When a path is disabled, addresses on that path pass through unchanged and every permission is granted.

Top module: `split_tlb_xlat`

## Requirements
- R1: After reset, `rsp_valid` and `exc_valid` are 0, `eaddr` is 0, `resv_addr` is all ones, and every table entry reads as tag 0 with valid clear.
- R2: A lookup presented with `req_valid` at a clock edge is answered with `rsp_valid` high for exactly the following cycle. On success `rsp_fault`=00 and `rsp_paddr` is the frame field (bits 31:13 of the frame word) followed by the virtual address bits 12:0.
- R3: The table index is virtual address bits 18:13. If tag word bits 31:13 differ from virtual address bits 31:13, `rsp_fault`=01 (no match), and `rsp_paddr` and `rsp_perm` are 0.
- R4: On a tag hit where tag word bit 0 (valid) is clear, `rsp_fault`=10 (invalid), and `rsp_paddr` and `rsp_perm` are 0.
- R5: A fetch (`req_kind`=10) is granted execute from frame word bit 5 in supervisor mode and bit 2 in user mode. Without execute it returns `rsp_fault`=11 (bad address). On success `rsp_perm` is {x,w,r}={x,0,0}.
- R6: A load (`req_kind`=00, and also 11) needs read and a store (`req_kind`=01) needs write. Read comes from frame word bit 3 (supervisor) or bit 0 (user). Write comes from bit 4 (supervisor) or bit 1 (user). A missing permission gives `rsp_fault`=11. On success `rsp_perm`={0,w,r}.
- R7: When `xlat_en_insn` is clear, fetches pass through; when `xlat_en_data` is clear, loads and stores pass through. A pass-through gives `rsp_paddr` equal to the virtual address, `rsp_perm`=111 and `rsp_fault`=00. Each enable affects only its own path.
- R8: `wr_dtlb`=0 writes the instruction table and 1 writes the data table. A write to one table never changes a lookup made on the other table.
- R9: Every failed lookup raises `exc_valid` in the cycle of its response. The cause is 00 for an instruction-table miss (no match or invalid on a fetch), 01 for a data-table miss, 10 for an instruction page fault (bad address on a fetch) and 11 for a data page fault.
- R10: On an exception, `eaddr` takes the faulting virtual address and `resv_addr` becomes all ones. Otherwise `eaddr` holds its value and `resv_addr` loads `resv_set_addr` only when `resv_set` is high.
- R11: If a table write and a lookup of the same entry share a cycle, the lookup sees the old contents. The new contents apply from the next lookup.
- R12: `exc_valid` lasts one cycle per failed lookup and is never high without `rsp_valid` and a nonzero `rsp_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| req_super | input | 1 | 1 = supervisor mode |
| xlat_en_insn | input | 1 | Instruction translation enable |
| xlat_en_data | input | 1 | Data translation enable |
| wr_en | input | 1 | Table word write strobe |
| wr_dtlb | input | 1 | 0 instruction table, 1 data table |
| wr_xlate | input | 1 | 0 tag word, 1 frame word |
| wr_index | input | 6 | Entry index |
| wr_data | input | 32 | Word to write |
| resv_set | input | 1 | Load a new reservation address |
| resv_set_addr | input | 32 | Reservation address to load |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted {x,w,r} |
| rsp_fault | output | 2 | 00 ok, 01 no match, 10 invalid, 11 bad address |
| exc_valid | output | 1 | Exception request pulse |
| exc_cause | output | 2 | Exception cause |
| eaddr | output | 32 | Captured faulting address |
| resv_addr | output | 32 | Load-linked reservation address |

## Verification
The bench aims at aliasing pairs of pages that share an index but differ in tag. A design that compared only the index bits would report a hit for these instead of no match. It uses entries whose user and supervisor permission groups disagree, so swapped mode selection shows up as a wrong grant or a wrong fault. It drives one enable low while the other stays high, which catches any shared or crossed enable. It also issues a write and a lookup to the same entry in one cycle, where a write-through read would return the new word too early. The offset 1FFF and the split between cause codes are checked so that truncated offsets and a miss mistaken for a page fault are caught.

// File: rtl/stlb_pkg.sv
package stlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_e;

  typedef enum logic [1:0] {
    FLT_OK      = 2'b00,
    FLT_NOMATCH = 2'b01,
    FLT_INVALID = 2'b10,
    FLT_BADADDR = 2'b11
  } flt_e;

  typedef enum logic [1:0] {
    EXC_IMISS = 2'b00,
    EXC_DMISS = 2'b01,
    EXC_IPF   = 2'b10,
    EXC_DPF   = 2'b11
  } exc_e;

  // permission group layout in the frame word: user [2:0], supervisor [5:3]
  localparam int unsigned PRM_W  = 6;
  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_W = 1;
  localparam int unsigned PERM_X = 2;

  // granted {x,w,r} from a frame word permission field
  function automatic logic [2:0] grant_bits(logic [PRM_W-1:0] tw, logic sup, logic fetch);
    logic [2:0] grp;
    grp = sup ? tw[5:3] : tw[2:0];
    return fetch ? {grp[PERM_X], 2'b00} : {1'b0, grp[PERM_W], grp[PERM_R]};
  endfunction

  function automatic logic access_ok(logic [2:0] g, logic fetch, logic store);
    if (fetch)      return g[PERM_X];
    else if (store) return g[PERM_W];
    else            return g[PERM_R];
  endfunction

  function automatic exc_e cause_of(flt_e f, logic fetch);
    if (f == FLT_BADADDR) return fetch ? EXC_IPF : EXC_DPF;
    else                  return fetch ? EXC_IMISS : EXC_DMISS;
  endfunction

endpackage

// File: rtl/stlb_bank.sv
module stlb_bank
  import stlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PO_W  = 13,
  parameter int IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_xlate,
  input  logic [IDX_W-1:0]     wr_index,
  input  logic [VA_W-1:0]      wr_data,
  input  logic [IDX_W-1:0]     rd_index,
  output logic [VA_W-PO_W-1:0] rd_tag,
  output logic                 rd_vld,
  output logic [VA_W-PO_W-1:0] rd_frm,
  output logic [PRM_W-1:0]     rd_prm
);
  localparam int TAG_W   = VA_W - PO_W;
  localparam int ENTRIES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic             vld_q [ENTRIES];
  logic [TAG_W-1:0] frm_q [ENTRIES];
  logic [PRM_W-1:0] prm_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        vld_q[i] <= 1'b0;
        frm_q[i] <= '0;
        prm_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_xlate) begin
        frm_q[wr_index] <= wr_data[VA_W-1:PO_W];
        prm_q[wr_index] <= wr_data[PRM_W-1:0];
      end else begin
        tag_q[wr_index] <= wr_data[VA_W-1:PO_W];
        vld_q[wr_index] <= wr_data[0];
      end
    end
  end

  // reads see the contents before any write at this edge
  assign rd_tag = tag_q[rd_index];
  assign rd_vld = vld_q[rd_index];
  assign rd_frm = frm_q[rd_index];
  assign rd_prm = prm_q[rd_index];

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[PO_W-1:PRM_W];

endmodule

// File: rtl/stlb_lookup.sv
module stlb_lookup
  import stlb_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PO_W = 13
) (
  input  logic                 en,
  input  logic                 is_fetch,
  input  logic                 is_store,
  input  logic                 sup,
  input  logic [VA_W-1:0]      vaddr,
  input  logic [VA_W-PO_W-1:0] tag,
  input  logic                 vld,
  input  logic [VA_W-PO_W-1:0] frm,
  input  logic [PRM_W-1:0]     prm,
  output logic                 tag_hit,
  output logic [VA_W-1:0]      paddr,
  output logic [2:0]           perm,
  output flt_e                 fault
);
  logic [2:0] grant;

  assign tag_hit = (tag == vaddr[VA_W-1:PO_W]);
  assign grant   = grant_bits(prm, sup, is_fetch);

  always_comb begin
    paddr = '0;
    perm  = 3'b000;
    fault = FLT_OK;
    if (!en) begin
      paddr = vaddr;
      perm  = 3'b111;
    end else if (!tag_hit) begin
      fault = FLT_NOMATCH;
    end else if (!vld) begin
      fault = FLT_INVALID;
    end else if (!access_ok(grant, is_fetch, is_store)) begin
      fault = FLT_BADADDR;
    end else begin
      paddr = {frm, vaddr[PO_W-1:0]};
      perm  = grant;
    end
  end

endmodule

// File: rtl/stlb_fault.sv
module stlb_fault
  import stlb_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  flt_e            fault,
  input  logic            is_fetch,
  input  logic [VA_W-1:0] vaddr,
  input  logic            resv_set,
  input  logic [VA_W-1:0] resv_set_addr,
  output logic            exc_valid,
  output logic [1:0]      exc_cause,
  output logic [VA_W-1:0] eaddr,
  output logic [VA_W-1:0] resv_addr
);
  logic raise;
  assign raise = fire && (fault != FLT_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_cause <= 2'b00;
      eaddr     <= '0;
      resv_addr <= '1;
    end else begin
      exc_valid <= raise;
      if (raise) begin
        exc_cause <= cause_of(fault, is_fetch);
        eaddr     <= vaddr;
        resv_addr <= '1;
      end else if (resv_set) begin
        resv_addr <= resv_set_addr;
      end
    end
  end

endmodule

// File: rtl/split_tlb_xlat.sv
module split_tlb_xlat
  import stlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PO_W  = 13,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_super,
  input  logic             xlat_en_insn,
  input  logic             xlat_en_data,
  input  logic             wr_en,
  input  logic             wr_dtlb,
  input  logic             wr_xlate,
  input  logic [IDX_W-1:0] wr_index,
  input  logic [VA_W-1:0]  wr_data,
  input  logic             resv_set,
  input  logic [VA_W-1:0]  resv_set_addr,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_perm,
  output logic [1:0]       rsp_fault,
  output logic             exc_valid,
  output logic [1:0]       exc_cause,
  output logic [VA_W-1:0]  eaddr,
  output logic [VA_W-1:0]  resv_addr
);
  localparam int TAG_W  = VA_W - PO_W;
  localparam int NBANK  = 2;
  localparam int B_INSN = 0;
  localparam int B_DATA = 1;

  logic             is_fetch, is_store;
  logic [IDX_W-1:0] lk_index;
  logic [TAG_W-1:0] bk_tag [NBANK];
  logic             bk_vld [NBANK];
  logic [TAG_W-1:0] bk_frm [NBANK];
  logic [PRM_W-1:0] bk_prm [NBANK];

  assign is_fetch = (req_kind == ACC_FETCH);
  assign is_store = (req_kind == ACC_STORE);
  assign lk_index = req_vaddr[PO_W +: IDX_W];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = wr_en && (wr_dtlb == (b == B_DATA));
    stlb_bank #(.VA_W(VA_W), .PO_W(PO_W), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_wr),
      .wr_xlate (wr_xlate),
      .wr_index (wr_index),
      .wr_data  (wr_data),
      .rd_index (lk_index),
      .rd_tag   (bk_tag[b]),
      .rd_vld   (bk_vld[b]),
      .rd_frm   (bk_frm[b]),
      .rd_prm   (bk_prm[b])
    );
  end

  // path selection: fetches use the instruction bank and its enable
  logic             lk_en;
  logic [TAG_W-1:0] sel_tag, sel_frm;
  logic             sel_vld;
  logic [PRM_W-1:0] sel_prm;
  assign lk_en   = is_fetch ? xlat_en_insn : xlat_en_data;
  assign sel_tag = is_fetch ? bk_tag[B_INSN] : bk_tag[B_DATA];
  assign sel_vld = is_fetch ? bk_vld[B_INSN] : bk_vld[B_DATA];
  assign sel_frm = is_fetch ? bk_frm[B_INSN] : bk_frm[B_DATA];
  assign sel_prm = is_fetch ? bk_prm[B_INSN] : bk_prm[B_DATA];

  logic            lk_tag_hit;
  logic [VA_W-1:0] lk_paddr;
  logic [2:0]      lk_perm;
  flt_e            lk_fault;

  stlb_lookup #(.VA_W(VA_W), .PO_W(PO_W)) u_lookup (
    .en       (lk_en),
    .is_fetch (is_fetch),
    .is_store (is_store),
    .sup      (req_super),
    .vaddr    (req_vaddr),
    .tag      (sel_tag),
    .vld      (sel_vld),
    .frm      (sel_frm),
    .prm      (sel_prm),
    .tag_hit  (lk_tag_hit),
    .paddr    (lk_paddr),
    .perm     (lk_perm),
    .fault    (lk_fault)
  );

  stlb_fault #(.VA_W(VA_W)) u_fault (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (req_valid),
    .fault         (lk_fault),
    .is_fetch      (is_fetch),
    .vaddr         (req_vaddr),
    .resv_set      (resv_set),
    .resv_set_addr (resv_set_addr),
    .exc_valid     (exc_valid),
    .exc_cause     (exc_cause),
    .eaddr         (eaddr),
    .resv_addr     (resv_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= 3'b000;
      rsp_fault <= 2'b00;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= lk_paddr;
        rsp_perm  <= lk_perm;
        rsp_fault <= lk_fault;
      end
    end
  end

  logic unused_hit;
  assign unused_hit = lk_tag_hit;

endmodule

// File: rtl/split_tlb_xlat_chk.sv
module split_tlb_xlat_chk #(
  parameter int VA_W = 32,
  parameter int PO_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic [1:0]      req_kind,
  input logic            xlat_en_insn,
  input logic            xlat_en_data,
  input logic            rsp_valid,
  input logic [VA_W-1:0] rsp_paddr,
  input logic [2:0]      rsp_perm,
  input logic [1:0]      rsp_fault,
  input logic            exc_valid,
  input logic [VA_W-1:0] eaddr,
  input logic [VA_W-1:0] resv_addr
);
  p_resp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_resp_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_fault != 2'b00 || rsp_paddr[PO_W-1:0] == $past(req_vaddr[PO_W-1:0])));
  p_fault_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0 && rsp_perm == 3'b000));
  p_fetch_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b10 && !xlat_en_insn) |=>
      (rsp_paddr == $past(req_vaddr) && rsp_perm == 3'b111 && rsp_fault == 2'b00));
  p_data_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'b10 && !xlat_en_data) |=>
      (rsp_paddr == $past(req_vaddr) && rsp_perm == 3'b111 && rsp_fault == 2'b00));
  p_exc_with_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (rsp_valid && rsp_fault != 2'b00));
  p_fault_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> exc_valid);
  p_eaddr_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!exc_valid || (eaddr == $past(req_vaddr) && resv_addr == '1)));
  p_eaddr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> $stable(eaddr));

endmodule

bind split_tlb_xlat split_tlb_xlat_chk #(.VA_W(VA_W), .PO_W(PO_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_vaddr    (req_vaddr),
  .req_kind     (req_kind),
  .xlat_en_insn (xlat_en_insn),
  .xlat_en_data (xlat_en_data),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_perm     (rsp_perm),
  .rsp_fault    (rsp_fault),
  .exc_valid    (exc_valid),
  .eaddr        (eaddr),
  .resv_addr    (resv_addr)
);

// File: tb/split_tlb_xlat_tb.sv
`timescale 1ns/1ps
module split_tlb_xlat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_super = 1'b0;
  logic        xlat_en_insn = 1'b1;
  logic        xlat_en_data = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_dtlb = 1'b0;
  logic        wr_xlate = 1'b0;
  logic [5:0]  wr_index = '0;
  logic [31:0] wr_data = '0;
  logic        resv_set = 1'b0;
  logic [31:0] resv_set_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;
  logic [1:0]  rsp_fault;
  logic        exc_valid;
  logic [1:0]  exc_cause;
  logic [31:0] eaddr;
  logic [31:0] resv_addr;

  int checks = 0;
  int failures = 0;

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, FE = 2'b10;

  split_tlb_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_super(req_super), .xlat_en_insn(xlat_en_insn),
    .xlat_en_data(xlat_en_data), .wr_en(wr_en), .wr_dtlb(wr_dtlb), .wr_xlate(wr_xlate),
    .wr_index(wr_index), .wr_data(wr_data), .resv_set(resv_set), .resv_set_addr(resv_set_addr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .eaddr(eaddr), .resv_addr(resv_addr)
  );

  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] va(logic [18:0] vpn, logic [12:0] off);
    return {vpn, off};
  endfunction
  function automatic logic [31:0] tagw(logic [18:0] vpn, logic v);
    return {vpn, 12'h000, v};
  endfunction
  // perm field: {sx,sw,sr,ux,uw,ur}
  function automatic logic [31:0] frmw(logic [18:0] pfn, logic [5:0] p);
    return {pfn, 7'h00, p};
  endfunction

  task automatic put(logic d, logic x, logic [18:0] vpn, logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_dtlb = d; wr_xlate = x; wr_index = vpn[5:0]; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // issue one lookup; outputs are sampled at the next falling edge
  task automatic look(logic [31:0] a, logic [1:0] k, logic s);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = a; req_kind = k; req_super = s;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(string tag, logic [31:0] pa, logic [2:0] pm, logic [1:0] f);
    check({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
    check({tag, " paddr"}, rsp_paddr, pa);
    check({tag, " perm"}, {29'b0, rsp_perm}, {29'b0, pm});
    check({tag, " fault"}, {30'b0, rsp_fault}, {30'b0, f});
  endtask

  task automatic expect_exc(string tag, logic e, logic [1:0] c, logic [31:0] a);
    check({tag, " exc"}, {31'b0, exc_valid}, {31'b0, e});
    if (e) begin
      check({tag, " cause"}, {30'b0, exc_cause}, {30'b0, c});
      check({tag, " eaddr"}, eaddr, a);
      check({tag, " resv"}, resv_addr, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_reset();
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 exc_valid", {31'b0, exc_valid}, 32'd0);
    check("R1 eaddr", eaddr, 32'd0);
    check("R1 resv", resv_addr, 32'hFFFF_FFFF);
    look(va(19'h0, 13'h10), LD, 1'b1);
    expect_rsp("R1 cleared entry", 32'd0, 3'b000, 2'b10);
  endtask

  task automatic t_fetch();
    put(1'b0, 1'b0, 19'h45, tagw(19'h45, 1'b1));
    put(1'b0, 1'b1, 19'h45, frmw(19'h1ABCD, 6'b100000));
    look(va(19'h45, 13'h123), FE, 1'b1);
    expect_rsp("R5 sup fetch", va(19'h1ABCD, 13'h123), 3'b100, 2'b00);
    expect_exc("R2 no exc on hit", 1'b0, 2'b00, 32'd0);
    look(va(19'h45, 13'h123), FE, 1'b0);
    expect_rsp("R5 user fetch no ux", 32'd0, 3'b000, 2'b11);
    expect_exc("R9 ipf", 1'b1, 2'b10, va(19'h45, 13'h123));
    @(negedge clk);
    check("R12 pulse ends", {31'b0, exc_valid}, 32'd0);
  endtask

  task automatic t_data();
    put(1'b1, 1'b0, 19'h45, tagw(19'h45, 1'b1));
    put(1'b1, 1'b1, 19'h45, frmw(19'h0F00F, 6'b010001));
    look(va(19'h45, 13'h1FFF), LD, 1'b0);
    expect_rsp("R6 user load", va(19'h0F00F, 13'h1FFF), 3'b001, 2'b00);
    look(va(19'h45, 13'h0004), ST, 1'b0);
    expect_rsp("R6 user store", 32'd0, 3'b000, 2'b11);
    expect_exc("R9 dpf", 1'b1, 2'b11, va(19'h45, 13'h0004));
    look(va(19'h45, 13'h0008), LD, 1'b1);
    expect_rsp("R6 sup load", 32'd0, 3'b000, 2'b11);
    look(va(19'h45, 13'h0000), ST, 1'b1);
    expect_rsp("R6 sup store", va(19'h0F00F, 13'h0000), 3'b010, 2'b00);
    look(va(19'h45, 13'h0040), 2'b11, 1'b0);
    expect_rsp("R6 kind 11 as load", va(19'h0F00F, 13'h0040), 3'b001, 2'b00);
  endtask

  task automatic t_miss();
    look(va(19'h85, 13'h0ABC), LD, 1'b1);
    expect_rsp("R3 alias nomatch", 32'd0, 3'b000, 2'b01);
    expect_exc("R9 dtlb miss", 1'b1, 2'b01, va(19'h85, 13'h0ABC));
    look(va(19'h7, 13'h0), FE, 1'b1);
    expect_rsp("R3 fetch nomatch", 32'd0, 3'b000, 2'b01);
    expect_exc("R9 itlb miss", 1'b1, 2'b00, va(19'h7, 13'h0));
    put(1'b1, 1'b0, 19'h30, tagw(19'h30, 1'b0));
    put(1'b1, 1'b1, 19'h30, frmw(19'h3, 6'b111111));
    look(va(19'h30, 13'h1), LD, 1'b1);
    expect_rsp("R4 data invalid", 32'd0, 3'b000, 2'b10);
    expect_exc("R9 invalid is miss", 1'b1, 2'b01, va(19'h30, 13'h1));
    put(1'b0, 1'b0, 19'h31, tagw(19'h31, 1'b0));
    look(va(19'h31, 13'h2), FE, 1'b0);
    expect_rsp("R4 fetch invalid", 32'd0, 3'b000, 2'b10);
    expect_exc("R9 fetch invalid is miss", 1'b1, 2'b00, va(19'h31, 13'h2));
  endtask

  task automatic t_separate();
    put(1'b0, 1'b0, 19'h46, tagw(19'h46, 1'b1));
    put(1'b0, 1'b1, 19'h46, frmw(19'h222, 6'b000100));
    look(va(19'h46, 13'h5), LD, 1'b0);
    expect_rsp("R8 data unaffected", 32'd0, 3'b000, 2'b01);
    look(va(19'h46, 13'h5), FE, 1'b0);
    expect_rsp("R8 insn written", va(19'h222, 13'h5), 3'b100, 2'b00);
  endtask

  task automatic t_bypass();
    xlat_en_data = 1'b0;
    look(32'h1234_5678, ST, 1'b0);
    expect_rsp("R7 data bypass", 32'h1234_5678, 3'b111, 2'b00);
    expect_exc("R7 bypass no exc", 1'b0, 2'b00, 32'd0);
    look(va(19'h7, 13'h0), FE, 1'b1);
    expect_rsp("R7 insn still on", 32'd0, 3'b000, 2'b01);
    xlat_en_data = 1'b1; xlat_en_insn = 1'b0;
    look(32'hDEAD_BEEF, FE, 1'b0);
    expect_rsp("R7 fetch bypass", 32'hDEAD_BEEF, 3'b111, 2'b00);
    look(32'hDEAD_BEEF, LD, 1'b0);
    expect_rsp("R7 data still on", 32'd0, 3'b000, 2'b01);
    xlat_en_insn = 1'b1;
  endtask

  task automatic t_same_cycle();
    put(1'b1, 1'b0, 19'h20, tagw(19'h20, 1'b1));
    put(1'b1, 1'b1, 19'h20, frmw(19'h55, 6'b000000));
    @(negedge clk);
    wr_en = 1'b1; wr_dtlb = 1'b1; wr_xlate = 1'b1; wr_index = 6'h20;
    wr_data = frmw(19'h55, 6'b000001);
    req_valid = 1'b1; req_vaddr = va(19'h20, 13'h9); req_kind = LD; req_super = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    expect_rsp("R11 old contents", 32'd0, 3'b000, 2'b11);
    look(va(19'h20, 13'h9), LD, 1'b0);
    expect_rsp("R11 new contents", va(19'h55, 13'h9), 3'b001, 2'b00);
  endtask

  task automatic t_resv();
    logic [31:0] held;
    @(negedge clk);
    resv_set = 1'b1; resv_set_addr = 32'h0000_1000;
    @(negedge clk);
    resv_set = 1'b0;
    check("R10 resv loaded", resv_addr, 32'h0000_1000);
    held = eaddr;
    look(va(19'h45, 13'h10), LD, 1'b0);
    check("R10 eaddr held", eaddr, held);
    check("R10 resv kept", resv_addr, 32'h0000_1000);
    look(va(19'h99, 13'h77), LD, 1'b0);
    expect_exc("R10 fault clears resv", 1'b1, 2'b01, va(19'h99, 13'h77));
    look(va(19'h99, 13'h77), LD, 1'b0);
    look(va(19'h45, 13'h10), LD, 1'b0);
    check("R12 no exc on ok", {31'b0, exc_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fetch();
    t_data();
    t_miss();
    t_separate();
    t_bypass();
    t_same_cycle();
    t_resv();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule